// File: doc/BRIEF.md
# Modular Fibonacci Line Descrambler

This block undoes a two-register modular Fibonacci scrambler on the receive side of a point-to-point serial link. Each scrambled word is 18 bits wide and takes two clock cycles. In the first cycle (phase 0) the word is taken in and the subtract and accumulate steps run. In the second cycle (phase 1) both results are folded back below the modulus. The recovered message is the scrambled word minus a rebuilt copy of the scrambler's second state register, together with the borrow left over from the previous word. That rebuilt copy is kept by a second accumulator. This accumulator adds a one-word-delayed copy of the line input into itself, modulo 258114. Because of this the descrambler locks onto the scrambler from the shared reset values, and the two never have to exchange any state.

The modular subtraction is built as an addition of the bitwise complement plus one carry input. That carry input is the inverted borrow flag. Two conditions raise a sticky error flag. The first is any line word at or above the modulus, seen in the cycle it arrives. The second is any recovered word with bit 17 set, which a legal message never has. The flag stays set until reset or until the clear input is driven. A two-state controller decides when each phase actually acts. A phase 1 cycle with no phase 0 before it does nothing, so the link can stall simply by holding phase at 1.

Top module: `modfib_descrambler`

## Requirements
- R1: After reset, valid_o and err_o are 0. The internal state starts at rebuilt-state 111981, delay register 56247, with both flags clear. As a result, the first word from a scrambler started with its first register at 56247 and its second at 111981 is recovered exactly.
- R2: For any sequence of messages below 2^17 that is scrambled and fed in order, each recovered message on msg_o equals the original message.
- R3: valid_o is 1 only in the cycle that follows a phase 1 cycle which itself followed a phase 0 cycle. valid_o is never 1 in two consecutive cycles.
- R4: A line word of 258114 or more, presented with phase_i = 0, sets err_o at that clock edge. The value 258113 does not set it.
- R5: A recovered word whose bit 17 is 1 sets err_o at the same edge that raises valid_o.
- R6: err_o stays 1 until reset or until clr_err_i is 1 at a clock edge where no new error is detected. A new error at the same edge wins over the clear.
- R7: A phase 1 cycle in the idle state is ignored: valid_o stays 0, msg_o holds its value, and the stream resumes with no loss when phase 0 comes back.
- R8: Messages at both ends of the range, 0 and 2^17-1, are recovered exactly, including words whose subtraction borrows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_i | input | 1 | 0: take in the word on sym_i; 1: fold the results |
| sym_i | input | 18 | Scrambled line word, sampled in phase 0 |
| clr_err_i | input | 1 | Clears the sticky error flag |
| msg_o | output | 18 | Recovered message, qualified by valid_o |
| valid_o | output | 1 | Recovered message is present in this cycle |
| err_o | output | 1 | Sticky error: invalid symbol or bit 17 set |

Controller states: ST_IDLE waits for phase 0. A phase 0 cycle moves it to ST_HALF, and a phase 1 cycle leaves it in ST_IDLE. In ST_HALF, a phase 1 cycle performs the fold and returns to ST_IDLE, while a phase 0 cycle takes in another word and stays in ST_HALF.

## Verification
The bench builds the block with its default parameters: an 18-bit word, modulus 258114 and the standard start values. This lets a bench-side model of the scrambler drive real line words. With this build the exact modulus boundary (258113 against 258114) is reachable, and random messages reach both the borrow path and the fold path. A single flip of bit 17 on a chosen word pushes the recovered value past 2^17, which exercises the bit-17 error. The sticky flag and its clear are then checked around that error.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HALF = 1'b1
    } dsc_state_e;
endpackage

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
    import dsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic phase_i,
    output logic acc_en_o,
    output logic fold_en_o,
    output logic valid_o
);
    dsc_state_e state_q;
    dsc_state_e state_d;
    logic       valid_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            valid_q <= fold_en_o;
        end
    end

    // next state and strobes
    always_comb begin
        state_d   = state_q;
        acc_en_o  = 1'b0;
        fold_en_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!phase_i) begin
                    acc_en_o = 1'b1;
                    state_d  = ST_HALF;
                end
            end
            ST_HALF: begin
                if (phase_i) begin
                    fold_en_o = 1'b1;
                    state_d   = ST_IDLE;
                end else begin
                    acc_en_o = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign valid_o = valid_q;
endmodule

// File: rtl/dsc_recover_lane.sv
module dsc_recover_lane #(
    parameter int W   = 18,
    parameter int ADJ = 4030
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_en,
    input  logic         fold_en,
    input  logic [W-1:0] sym,
    input  logic [W-1:0] state_b,
    output logic [W-1:0] msg,
    output logic         hi_bit
);
    localparam logic [W:0] ADJ_V = (W+1)'(ADJ);

    logic [W:0] acc_q;
    logic       borrow_q;
    logic [W:0] diff;
    logic [W:0] reduced;
    logic [W:0] fold_next;

    // subtraction as complement plus a single carry-in (inverted borrow)
    always_comb begin
        diff      = {1'b0, sym} + ~{1'b0, state_b} + {{W{1'b0}}, ~borrow_q};
        reduced   = acc_q - ADJ_V;
        fold_next = acc_q[W] ? {1'b0, reduced[W-1:0]} : acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            borrow_q <= 1'b0;
        end else if (acc_en) begin
            acc_q <= diff;
        end else if (fold_en) begin
            borrow_q <= acc_q[W];
            acc_q    <= fold_next;
        end
    end

    assign msg    = acc_q[W-1:0];
    assign hi_bit = fold_next[W-1];
endmodule

// File: rtl/dsc_track_lane.sv
module dsc_track_lane #(
    parameter int W      = 18,
    parameter int ADJ    = 4030,
    parameter int INIT_B = 111981,
    parameter int INIT_T = 56247
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_en,
    input  logic         fold_en,
    input  logic [W-1:0] sym,
    output logic [W-1:0] state_b
);
    localparam logic [W:0]   ADJ_V  = (W+1)'(ADJ);
    localparam logic [W:0]   INIT_BV = (W+1)'(INIT_B);
    localparam logic [W-1:0] INIT_TV = W'(INIT_T);

    logic [W-1:0] dly_q;
    logic [W:0]   b_q;
    logic         carry_q;
    logic [W:0]   sum;
    logic [W:0]   probe;

    always_comb begin
        sum   = {1'b0, dly_q} + b_q + {{W{1'b0}}, carry_q};
        probe = b_q + ADJ_V;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q   <= INIT_TV;
            b_q     <= INIT_BV;
            carry_q <= 1'b0;
        end else if (acc_en) begin
            b_q   <= sum;
            dly_q <= sym;
        end else if (fold_en) begin
            carry_q <= probe[W];
            if (probe[W]) b_q <= {1'b0, probe[W-1:0]};
        end
    end

    assign state_b = b_q[W-1:0];
endmodule

// File: rtl/dsc_err.sv
module dsc_err #(
    parameter int W       = 18,
    parameter int MODULUS = 258114
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_en,
    input  logic         fold_en,
    input  logic [W-1:0] sym,
    input  logic         hi_bit,
    input  logic         clr,
    output logic         err
);
    localparam logic [W-1:0] MOD_V = W'(MODULUS);

    logic err_q;
    logic set_now;

    always_comb begin
        set_now = (acc_en && (sym >= MOD_V)) || (fold_en && hi_bit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (set_now) err_q <= 1'b1;
        else if (clr)     err_q <= 1'b0;
    end

    assign err = err_q;
endmodule

// File: rtl/modfib_descrambler.sv
module modfib_descrambler #(
    parameter int W       = 18,
    parameter int MODULUS = 258114,
    parameter int INIT_B  = 111981,
    parameter int INIT_T  = 56247
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         phase_i,
    input  logic [W-1:0] sym_i,
    input  logic         clr_err_i,
    output logic [W-1:0] msg_o,
    output logic         valid_o,
    output logic         err_o
);
    localparam int ADJUST = (2 ** W) - MODULUS;

    logic         acc_en;
    logic         fold_en;
    logic [W-1:0] state_b;
    logic         hi_bit;

    dsc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_i   (phase_i),
        .acc_en_o  (acc_en),
        .fold_en_o (fold_en),
        .valid_o   (valid_o)
    );

    dsc_recover_lane #(.W(W), .ADJ(ADJUST)) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (acc_en),
        .fold_en (fold_en),
        .sym     (sym_i),
        .state_b (state_b),
        .msg     (msg_o),
        .hi_bit  (hi_bit)
    );

    dsc_track_lane #(.W(W), .ADJ(ADJUST), .INIT_B(INIT_B), .INIT_T(INIT_T)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (acc_en),
        .fold_en (fold_en),
        .sym     (sym_i),
        .state_b (state_b)
    );

    dsc_err #(.W(W), .MODULUS(MODULUS)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (acc_en),
        .fold_en (fold_en),
        .sym     (sym_i),
        .hi_bit  (hi_bit),
        .clr     (clr_err_i),
        .err     (err_o)
    );
endmodule

// File: rtl/modfib_descrambler_chk.sv
module modfib_descrambler_chk #(
    parameter int W       = 18,
    parameter int MODULUS = 258114
) (
    input logic         clk,
    input logic         rst_n,
    input logic         phase_i,
    input logic [W-1:0] sym_i,
    input logic         clr_err_i,
    input logic [W-1:0] msg_o,
    input logic         valid_o,
    input logic         err_o
);
    localparam logic [W-1:0] MOD_V = W'(MODULUS);

    AST_VALID_AFTER_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(phase_i)); // R3
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R3
    AST_BAD_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_i && sym_i >= MOD_V) |=> err_o); // R4
    AST_MSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !err_o) |-> !msg_o[W-1]); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !clr_err_i) |=> err_o); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && phase_i) |=> ($stable(msg_o) && !valid_o)); // R7
endmodule

bind modfib_descrambler modfib_descrambler_chk #(.W(W), .MODULUS(MODULUS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_i   (phase_i),
    .sym_i     (sym_i),
    .clr_err_i (clr_err_i),
    .msg_o     (msg_o),
    .valid_o   (valid_o),
    .err_o     (err_o)
);

// File: tb/modfib_descrambler_tb.sv
module modfib_descrambler_tb;
    localparam int MOD  = 258114;
    localparam int ADJ  = 262144 - MOD;
    localparam int MASK = 262143;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_i = 1'b1;
    logic [17:0] sym_i = '0;
    logic        clr_err_i = 1'b0;
    logic [17:0] msg_o;
    logic        valid_o;
    logic        err_o;

    int n_chk = 0;
    int n_bad = 0;
    int sx, sy, sv, sw;

    always #10 clk = ~clk;

    modfib_descrambler u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_i   (phase_i),
        .sym_i     (sym_i),
        .clr_err_i (clr_err_i),
        .msg_o     (msg_o),
        .valid_o   (valid_o),
        .err_o     (err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_init();
        sx = 56247; sy = 111981; sv = 0; sw = 0;
    endtask

    // bench model of the scrambler: returns the next line word
    function automatic int scr_step(input int m);
        int x2, y2, x3, y3;
        x2 = m + sy + sv;
        y2 = sx + sy + sw;
        x3 = x2 + ADJ;
        y3 = y2 + ADJ;
        sv = (x3 >> 18) & 1;
        sw = (y3 >> 18) & 1;
        sx = sv ? (x3 & MASK) : x2;
        sy = sw ? (y3 & MASK) : y2;
        return sx;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; phase_i = 1'b1; clr_err_i = 1'b0; sym_i = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_init();
    endtask

    // drive one word (phase 0 then phase 1), check the recovered message
    task automatic send_word(input int m, input string req);
        int x;
        x = scr_step(m);
        phase_i = 1'b0; sym_i = 18'(x);
        @(negedge clk);
        chk(valid_o == 1'b0, "R3", int'(valid_o), 0);
        phase_i = 1'b1;
        @(negedge clk);
        chk(valid_o == 1'b1, "R3", int'(valid_o), 1);
        chk(int'(msg_o) == m, req, int'(msg_o), m);
        chk(err_o == 1'b0, req, int'(err_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit done;
        int prev;
        do_reset();
        // R1 reset state and first word
        chk(valid_o == 1'b0, "R1", int'(valid_o), 0);
        chk(err_o == 1'b0, "R1", int'(err_o), 0);
        send_word(32'h00123, "R1");
        // R8 range ends
        send_word(0, "R8");
        send_word(32'h1FFFF, "R8");
        send_word(0, "R8");
        send_word(32'h1FFFF, "R8");
        // R2 random stream
        void'($urandom(32'd7));
        for (int i = 0; i < 400; i++) send_word(int'($urandom() & 32'h1FFFF), "R2");

        // R7 idle gap holding phase at 1
        prev = int'(msg_o);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(valid_o == 1'b0, "R7", int'(valid_o), 0);
            chk(int'(msg_o) == prev, "R7", int'(msg_o), prev);
        end
        for (int i = 0; i < 20; i++) send_word(int'($urandom() & 32'h1FFFF), "R7");

        // R4 boundary: modulus minus one accepted at phase 0
        do_reset();
        phase_i = 1'b0; sym_i = 18'(MOD - 1);
        @(negedge clk);
        chk(err_o == 1'b0, "R4", int'(err_o), 0);
        // R4 modulus itself flagged
        do_reset();
        phase_i = 1'b0; sym_i = 18'(MOD);
        @(negedge clk);
        chk(err_o == 1'b1, "R4", int'(err_o), 1);
        phase_i = 1'b1;
        repeat (4) @(negedge clk);
        chk(err_o == 1'b1, "R6", int'(err_o), 1);
        // R6 clear loses to a simultaneous new error
        phase_i = 1'b0; sym_i = 18'h3FFFF; clr_err_i = 1'b1;
        @(negedge clk);
        chk(err_o == 1'b1, "R6", int'(err_o), 1);
        phase_i = 1'b1;
        @(negedge clk);
        clr_err_i = 1'b0;
        chk(err_o == 1'b0, "R6", int'(err_o), 0);

        // R5 bit-17 flip on a suitable word
        do_reset();
        done = 1'b0;
        for (int i = 0; i < 300 && !done; i++) begin
            int m, x;
            m = int'($urandom() & 32'hFFFF);
            x = scr_step(m);
            phase_i = 1'b0;
            if (((x >> 17) & 1) == 0 && (x + 131072) < MOD) begin
                sym_i = 18'(x + 131072);
                @(negedge clk);
                chk(err_o == 1'b0, "R5", int'(err_o), 0);
                phase_i = 1'b1;
                @(negedge clk);
                chk(valid_o == 1'b1, "R5", int'(valid_o), 1);
                chk(err_o == 1'b1, "R5", int'(err_o), 1);
                chk(int'(msg_o) == m + 131072, "R5", int'(msg_o), m + 131072);
                done = 1'b1;
            end else begin
                sym_i = 18'(x);
                @(negedge clk);
                phase_i = 1'b1;
                @(negedge clk);
                chk(int'(msg_o) == m, "R2", int'(msg_o), m);
            end
        end
        chk(done, "R5", int'(done), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule